// File: doc/BRIEF.md
# Calendar Timekeeping Core with Binary/BCD Counting

This block holds the time of day and the calendar as eight byte registers: seconds, minutes, hours, day of week, date, month, two-digit year and a century byte. Each one-cycle `pps` strobe advances the whole set by one second through a single carry chain. The chain counts in either packed BCD or plain binary, chosen by `bin_mode`. Hours run in 24-hour form or in 12-hour form with a PM flag, and February gets its 29th day in leap years.

Software stops the advance by raising `set_hold`. While the hold is up, it writes any time byte or any alarm byte through a select/data load port. It then drops the hold and counting resumes. After every advance, the block compares seconds, minutes and hours against three alarm bytes and pulses `alarm_match`.

A three-state sequencer drives the update. **ST_IDLE** waits for a strobe. The transition *start* (`pps` high and `set_hold` low) leads to **ST_STEP**, in which the registers take the next-second values. The unconditional transition *commit* leads to **ST_MATCH**, where the alarm comparison is presented. The unconditional transition *finish* returns to **ST_IDLE**. A strobe that arrives in ST_STEP or ST_MATCH is dropped. A strobe in ST_IDLE while the hold is up is dropped through the transition *stay*.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds count 0..59 and minutes count 0..59. Seconds wrap to 0 on every strobe that finds them at 59 and carry into minutes; minutes wrap the same way and carry into hours.
- R2: With `bin_mode`=0 every byte is packed BCD (tens in bits 7:4, units in bits 3:0), so 0x09 steps to 0x10 and 0x59 wraps to 0x00. With `bin_mode`=1 bytes are plain binary, so 59 (0x3B) wraps to 0.
- R3: With `mode_24h`=1, hours count 0..23. Hour 23 wraps to 0 and produces a day carry.
- R4: With `mode_24h`=0, bit 7 of the hour byte is PM (1 = PM) and bits 6:0 hold 1..12. Hour 11 steps to 12 and toggles PM. Hour 12 steps to 1 and keeps PM. A day carry happens only on 11 PM to 12 AM.
- R5: Day of week counts 1..7, advances on each day carry, and wraps 7 to 1.
- R6: The date counts from 1 up to the month length: 30 for April, June, September and November, and 31 for the other months except February. February has 29 days when the year value is divisible by 4 and 28 otherwise. The date wraps to 1 and carries into the month.
- R7: The month wraps 12 to 1 and carries into the year. The year wraps 99 to 0 and carries into the century byte, which wraps 99 to 0.
- R8: While `set_hold`=1, strobes are ignored and loads are taken. With `set_hold`=0, loads are ignored. `ld_sel` codes: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century, 8 alarm seconds, 9 alarm minutes, 10 alarm hours. Codes 11..15 write nothing.
- R9: A strobe sampled at rising edge N updates the time bytes at edge N+1. They do not change at any other edge except through a load.
- R10: `alarm_match` is high for exactly the one cycle after edge N+1 when the advanced seconds, minutes and full hour byte (PM flag included) equal the alarm bytes. Loads alone never raise it.
- R11: A loaded value that is not a legal code for its byte, such as a BCD nibble above 9, is kept unchanged while the hold stays up. It is not altered by loads to other bytes.
- R12: A strobe that stays high for several cycles advances the time only once, because strobes seen in ST_STEP or ST_MATCH are dropped.
- R13: Reset (`rst_n` low) gives 00:00:00, day of week 1, date 1, month 1, year 0, century 0, and `alarm_match` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps | input | 1 | One-second advance strobe |
| set_hold | input | 1 | 1 = freeze advancing and allow loads |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed BCD |
| mode_24h | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 4 | Register select for a load |
| ld_data | input | 8 | Load value |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Date in month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| century_o | output | 8 | Century |
| alarm_match | output | 1 | One-cycle alarm compare pulse |

## Verification
A wrong carry or a wrong wrap limit shows at the byte outputs two edges after the strobe, in the first sample after the advance. A fault in the calendar chain shows only at a day boundary, so the stimulus loads values just before each boundary (23:59:59 at month ends, February in leap and common years, 11:59:59 AM and PM) and then issues a single strobe. A sequencer that stalls, repeats a step or takes a strobe during the hold shows as a seconds byte that is off by one in the same sample. A bad comparison shows as an `alarm_match` pulse that is missing, stretched or spurious in the cycle after the update.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_MATCH = 2'd2
    } step_state_e;

    // load select codes
    localparam logic [SEL_W-1:0] SEL_SEC   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_MIN   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_HOUR  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_DOW   = 4'd3;
    localparam logic [SEL_W-1:0] SEL_DATE  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_MON   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_YEAR  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_CENT  = 4'd7;
    localparam logic [SEL_W-1:0] SEL_ASEC  = 4'd8;
    localparam logic [SEL_W-1:0] SEL_AMIN  = 4'd9;
    localparam logic [SEL_W-1:0] SEL_AHOUR = 4'd10;

    // value 0..99 to byte code in the active mode
    function automatic byte_t enc(input logic [6:0] v, input logic bin);
        byte_t w;
        w = {1'b0, v};
        return bin ? w : (((w / 8'd10) << 4) | (w % 8'd10));
    endfunction

    // byte code to value in the active mode
    function automatic logic [6:0] dec(input byte_t c, input logic bin);
        return bin ? c[6:0] : 7'({4'd0, c[7:4]} * 8'd10 + {4'd0, c[3:0]});
    endfunction

    // plus one in the active mode, no wrap
    function automatic byte_t bump(input byte_t c, input logic bin);
        if (bin || c[3:0] < 4'd9) return c + 8'd1;
        return {c[7:4] + 4'd1, 4'd0};
    endfunction

endpackage

// File: rtl/rtc_wrap_ctr.sv
module rtc_wrap_ctr
    import rtc_cal_pkg::*;
(
    input  byte_t      cur,
    input  logic [6:0] lo,
    input  logic [6:0] hi,
    input  logic       bin,
    input  logic       cin,
    output byte_t      nxt,
    output logic       cout
);
    logic at_top;

    // anything at or past the top code, legal or not, wraps to the bottom
    assign at_top = (cur >= enc(hi, bin));
    assign cout   = cin & at_top;

    always_comb begin
        if (!cin)        nxt = cur;
        else if (at_top) nxt = enc(lo, bin);
        else             nxt = bump(cur, bin);
    end
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
    import rtc_cal_pkg::*;
(
    input  byte_t cur,
    input  logic  bin,
    input  logic  h24,
    input  logic  cin,
    output byte_t nxt,
    output logic  cout
);
    byte_t low;
    logic  pm;
    byte_t c11, c12, c23, c01;

    assign low = {1'b0, cur[6:0]};
    assign pm  = cur[7];
    assign c11 = enc(7'd11, bin);
    assign c12 = enc(7'd12, bin);
    assign c23 = enc(7'd23, bin);
    assign c01 = enc(7'd1,  bin);

    always_comb begin
        nxt  = cur;
        cout = 1'b0;
        if (cin) begin
            if (h24) begin
                if (cur >= c23) begin
                    nxt  = 8'd0;
                    cout = 1'b1;
                end else begin
                    nxt  = bump(cur, bin);
                end
            end else begin
                if (low >= c12) begin
                    nxt = {pm, c01[6:0]};          // 12 -> 1, PM kept
                end else if (low == c11) begin
                    nxt  = {~pm, c12[6:0]};        // 11 -> 12, PM flips
                    cout = pm;                     // 11 PM -> 12 AM ends the day
                end else begin
                    nxt = {pm, 7'(bump(low, bin))};
                end
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_cal_pkg::*;
(
    input  byte_t      month,
    input  byte_t      year,
    input  logic       bin,
    output logic [6:0] dim
);
    logic [6:0] mb, yb;
    logic       leap;

    assign mb   = dec(month, bin);
    assign yb   = dec(year, bin);
    assign leap = ((yb & 7'd3) == 7'd0);

    always_comb begin
        unique case (mb)
            7'd2:                         dim = leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:      dim = 7'd30;
            default:                      dim = 7'd31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps,
    input  logic             set_hold,
    input  logic             bin_mode,
    input  logic             mode_24h,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [BYTE_W-1:0] ld_data,
    output logic [BYTE_W-1:0] sec_o,
    output logic [BYTE_W-1:0] min_o,
    output logic [BYTE_W-1:0] hour_o,
    output logic [BYTE_W-1:0] dow_o,
    output logic [BYTE_W-1:0] date_o,
    output logic [BYTE_W-1:0] month_o,
    output logic [BYTE_W-1:0] year_o,
    output logic [BYTE_W-1:0] century_o,
    output logic             alarm_match
);
    step_state_e state_q, state_d;

    byte_t sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q, cent_q;
    byte_t asec_q, amin_q, ahour_q;
    byte_t sec_n, min_n, hour_n, dow_n, date_n, mon_n, year_n, cent_n;
    logic  c_sec, c_min, c_day, c_dow, c_date, c_mon, c_year, c_cent;
    logic  [6:0] dim;
    logic  load_now;
    logic  stepped_q;
    logic  [8*BYTE_W-1:0] t_flat;

    assign load_now = set_hold & ld_en;
    assign t_flat   = {sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q, cent_q};

    // ---------------- carry chain ----------------
    rtc_month_len u_len (.month(mon_q), .year(year_q), .bin(bin_mode), .dim(dim));

    rtc_wrap_ctr u_sec  (.cur(sec_q),  .lo(7'd0), .hi(7'd59), .bin(bin_mode), .cin(1'b1),
                         .nxt(sec_n),  .cout(c_sec));
    rtc_wrap_ctr u_min  (.cur(min_q),  .lo(7'd0), .hi(7'd59), .bin(bin_mode), .cin(c_sec),
                         .nxt(min_n),  .cout(c_min));
    rtc_hour_ctr u_hour (.cur(hour_q), .bin(bin_mode), .h24(mode_24h), .cin(c_min),
                         .nxt(hour_n), .cout(c_day));
    rtc_wrap_ctr u_dow  (.cur(dow_q),  .lo(7'd1), .hi(7'd7),  .bin(bin_mode), .cin(c_day),
                         .nxt(dow_n),  .cout(c_dow));
    rtc_wrap_ctr u_date (.cur(date_q), .lo(7'd1), .hi(dim),   .bin(bin_mode), .cin(c_day),
                         .nxt(date_n), .cout(c_date));
    rtc_wrap_ctr u_mon  (.cur(mon_q),  .lo(7'd1), .hi(7'd12), .bin(bin_mode), .cin(c_date),
                         .nxt(mon_n),  .cout(c_mon));
    rtc_wrap_ctr u_year (.cur(year_q), .lo(7'd0), .hi(7'd99), .bin(bin_mode), .cin(c_mon),
                         .nxt(year_n), .cout(c_year));
    rtc_wrap_ctr u_cent (.cur(cent_q), .lo(7'd0), .hi(7'd99), .bin(bin_mode), .cin(c_year),
                         .nxt(cent_n), .cout(c_cent));

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pps && !set_hold) state_d = ST_STEP;   // start / stay
            ST_STEP:  state_d = ST_MATCH;                        // commit
            ST_MATCH: state_d = ST_IDLE;                         // finish
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- byte registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= 8'd0;  min_q  <= 8'd0;  hour_q <= 8'd0;  dow_q   <= 8'd1;
            date_q <= 8'd1;  mon_q  <= 8'd1;  year_q <= 8'd0;  cent_q  <= 8'd0;
            asec_q <= 8'hFF; amin_q <= 8'hFF; ahour_q <= 8'hFF;
            stepped_q <= 1'b0;
        end else begin
            stepped_q <= (state_q == ST_STEP) && !load_now;
            if (load_now) begin
                unique case (ld_sel)
                    SEL_SEC:   sec_q   <= ld_data;
                    SEL_MIN:   min_q   <= ld_data;
                    SEL_HOUR:  hour_q  <= ld_data;
                    SEL_DOW:   dow_q   <= ld_data;
                    SEL_DATE:  date_q  <= ld_data;
                    SEL_MON:   mon_q   <= ld_data;
                    SEL_YEAR:  year_q  <= ld_data;
                    SEL_CENT:  cent_q  <= ld_data;
                    SEL_ASEC:  asec_q  <= ld_data;
                    SEL_AMIN:  amin_q  <= ld_data;
                    SEL_AHOUR: ahour_q <= ld_data;
                    default: ;
                endcase
            end else if (state_q == ST_STEP) begin
                sec_q  <= sec_n;   min_q  <= min_n;   hour_q <= hour_n;  dow_q  <= dow_n;
                date_q <= date_n;  mon_q  <= mon_n;   year_q <= year_n;  cent_q <= cent_n;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sec_o     = sec_q;
        min_o     = min_q;
        hour_o    = hour_q;
        dow_o     = dow_q;
        date_o    = date_q;
        month_o   = mon_q;
        year_o    = year_q;
        century_o = cent_q;
        alarm_match = (state_q == ST_MATCH) && stepped_q &&
                      (sec_q == asec_q) && (min_q == amin_q) && (hour_q == ahour_q);
    end

    // ---------------- assertions ----------------
    a_r8_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && set_hold) |=> (state_q != ST_STEP));

    a_r12_step_then_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> (state_q == ST_MATCH));

    a_r9_quiet_off_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STEP && !load_now) |=> $stable(t_flat));

    a_r11_hold_keeps_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && !ld_en && state_q != ST_STEP) |=> $stable(t_flat));

    a_r1_seconds_move: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && !load_now) |=> (sec_q != $past(sec_q)));

    a_r4_hour12_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && !load_now && !mode_24h) |=> (hour_q[6:0] != 7'd0));

    a_r5_dow_wraps_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && !load_now && c_dow) |=> (dow_q == 8'd1));

    a_r7_century_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && !load_now && c_cent) |=> (cent_q == 8'd0));

    a_r10_match_single: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_match |=> !alarm_match);
endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pps = 1'b0, set_hold = 1'b0, bin_mode = 1'b0, mode_24h = 1'b1;
    logic       ld_en = 1'b0;
    logic [3:0] ld_sel = 4'd0;
    logic [7:0] ld_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, century_o;
    logic       alarm_match;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rtc_calendar_core u_dut (
        .clk(clk), .rst_n(rst_n), .pps(pps), .set_hold(set_hold), .bin_mode(bin_mode),
        .mode_24h(mode_24h), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
        .month_o(month_o), .year_o(year_o), .century_o(century_o), .alarm_match(alarm_match));

    wire [63:0] now_t = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, century_o};

    // {bin_mode, mode_24h, start {s,m,h,dow,date,mon,yr,cent}, expected after one strobe}
    localparam int NV = 17;
    localparam logic [129:0] VEC [NV] = '{
        {1'b0, 1'b1, 64'h56341203_15062420, 64'h57341203_15062420}, // R1 plain step
        {1'b0, 1'b1, 64'h09000001_01010020, 64'h10000001_01010020}, // R2 BCD nibble carry
        {1'b0, 1'b1, 64'h59592307_31129920, 64'h00000001_01010021}, // R3 R5 R7 full rollover
        {1'b0, 1'b1, 64'h59592303_28022420, 64'h00000004_29022420}, // R6 leap Feb 28
        {1'b0, 1'b1, 64'h59592304_29022420, 64'h00000005_01032420}, // R6 leap Feb 29
        {1'b0, 1'b1, 64'h59592302_28022320, 64'h00000003_01032320}, // R6 common Feb 28
        {1'b0, 1'b1, 64'h59592305_30042520, 64'h00000006_01052520}, // R6 30-day month
        {1'b1, 1'b1, 64'h3B3B1707_1F0C6314, 64'h00000001_01010015}, // R2 binary rollover
        {1'b1, 1'b1, 64'h3B3B1701_1C021814, 64'h00000002_1D021814}, // R6 binary leap
        {1'b0, 1'b0, 64'h59591102_10052520, 64'h00009202_10052520}, // R4 11 AM -> 12 PM
        {1'b0, 1'b0, 64'h59599202_10052520, 64'h00008102_10052520}, // R4 12 PM -> 1 PM
        {1'b0, 1'b0, 64'h59599102_10052520, 64'h00001203_11052520}, // R4 11 PM -> 12 AM
        {1'b1, 1'b0, 64'h3B3B8B02_0A051914, 64'h00000C03_0B051914}, // R4 binary 12-hour
        {1'b0, 1'b1, 64'h59590901_01010020, 64'h00001001_01010020}, // R3 hour BCD carry
        {1'b0, 1'b1, 64'h59592307_31129999, 64'h00000001_01010000}, // R7 century wrap
        {1'b1, 1'b1, 64'h3B3B1706_1E061814, 64'h00000007_01071814}, // R6 binary June 30
        {1'b1, 1'b1, 64'h3B3B1701_1C021714, 64'h00000002_01031714}  // R6 binary common Feb
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_one(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all(input logic b, input logic h, input logic [63:0] st,
                            input logic [7:0] as, input logic [7:0] am, input logic [7:0] ah);
        @(negedge clk);
        set_hold = 1'b1; bin_mode = b; mode_24h = h;
        for (int k = 0; k < 8; k++) begin
            ld_en = 1'b1; ld_sel = 4'(k); ld_data = st[63-8*k -: 8];
            @(negedge clk);
        end
        ld_en = 1'b1; ld_sel = 4'd8;  ld_data = as; @(negedge clk);
        ld_en = 1'b1; ld_sel = 4'd9;  ld_data = am; @(negedge clk);
        ld_en = 1'b1; ld_sel = 4'd10; ld_data = ah; @(negedge clk);
        ld_en = 1'b0; set_hold = 1'b0;
    endtask

    // returns at the first falling edge after the update edge
    task automatic tick();
        @(negedge clk) pps = 1'b1;
        @(negedge clk) pps = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset contents
        chk("R13 reset bytes", now_t, 64'h00000001_01010000);
        chk("R13 reset alarm", {63'd0, alarm_match}, 64'd0);

        // table walk: R1..R7 boundary vectors
        for (int v = 0; v < NV; v++) begin
            load_all(VEC[v][129], VEC[v][128], VEC[v][127:64], 8'hFF, 8'hFF, 8'hFF);
            tick();
            chk($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", v), now_t, VEC[v][63:0]);
            chk($sformatf("R10 no match vector %0d", v), {63'd0, alarm_match}, 64'd0);
        end

        // R9 update timing
        load_all(1'b0, 1'b1, 64'h10000001_01010020, 8'hFF, 8'hFF, 8'hFF);
        @(negedge clk) pps = 1'b1;
        @(negedge clk) pps = 1'b0;
        chk("R9 no change one edge after strobe", {56'd0, sec_o}, 64'h10);
        @(negedge clk);
        chk("R9 change two edges after strobe", {56'd0, sec_o}, 64'h11);

        // R8 strobe ignored under hold
        @(negedge clk) set_hold = 1'b1;
        @(negedge clk) pps = 1'b1;
        repeat (3) @(negedge clk);
        pps = 1'b0;
        @(negedge clk);
        chk("R8 strobe ignored while held", now_t, 64'h11000001_01010020);
        // R8 unused select codes write nothing
        load_one(4'd11, 8'h00);
        load_one(4'd15, 8'h00);
        chk("R8 unused select codes", now_t, 64'h11000001_01010020);
        set_hold = 1'b0;
        // R8 load ignored without hold
        load_one(4'd0, 8'h33);
        chk("R8 load ignored when not held", {56'd0, sec_o}, 64'h11);

        // R12 long strobe advances once
        @(negedge clk) pps = 1'b1;
        repeat (3) @(negedge clk);
        pps = 1'b0;
        @(negedge clk);
        chk("R12 long strobe single advance", {56'd0, sec_o}, 64'h12);

        // R11 illegal code held
        @(negedge clk) set_hold = 1'b1;
        load_one(4'd0, 8'h7A);
        load_one(4'd1, 8'h45);
        @(negedge clk) pps = 1'b1;
        @(negedge clk) pps = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 illegal seconds kept", {48'd0, sec_o, min_o}, 64'h7A45);
        set_hold = 1'b0;

        // R10 alarm match after advance
        load_all(1'b0, 1'b1, 64'h29201003_15062420, 8'h30, 8'h20, 8'h10);
        chk("R10 no match from loads", {63'd0, alarm_match}, 64'd0);
        tick();
        chk("R10 match pulse", {55'd0, sec_o, alarm_match}, {55'd0, 8'h30, 1'b1});
        @(negedge clk);
        chk("R10 match lasts one cycle", {63'd0, alarm_match}, 64'd0);

        // R10 PM flag takes part in the compare
        load_all(1'b0, 1'b0, 64'h59591203_15062420, 8'h00, 8'h00, 8'h81);
        tick();
        chk("R10 PM mismatch", {55'd0, hour_o, alarm_match}, {55'd0, 8'h01, 1'b0});
        load_all(1'b0, 1'b0, 64'h59591203_15062420, 8'h00, 8'h00, 8'h01);
        tick();
        chk("R10 AM match", {55'd0, hour_o, alarm_match}, {55'd0, 8'h01, 1'b1});

        // R9 registers stay put with no strobe
        snap = now_t;
        repeat (5) @(negedge clk);
        chk("R9 idle stability", now_t, snap);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule